// File: doc/BRIEF.md
# JTAG Scan Chain Length Probe

This block is a host-side sequencer that measures how many test access ports are daisy-chained between its TDI output and its TDO input. After a start pulse it generates TCK from the system clock and uses the shared TMS line to put every TAP into Test-Logic-Reset. It then loads an instruction of all ones into the concatenated instruction path, which selects BYPASS in every device. A single marker bit is then walked through the data path, and the number of TCK cycles it takes to come back is the device count.

In BYPASS, each device adds a one-bit register between its TDI and TDO. The delay seen at TDO is therefore one TCK per device. The result comes from that measured delay alone and needs no stored knowledge of the board. A chain that is open or stuck is reported through an error flag with a count of zero. At the end of a run every TAP is back in Run-Test/Idle, and the result stays on the outputs until the next start.

Top module: `tap_chain_sizer`

## Requirements
- R1: After reset, busy, done, err, tck, tms and tdi are all 0 and dev_count is 0.
- R2: While busy, TCK is a square wave with a period of 2·TCK_DIV system clocks, and its first edge after start is a rising one. While not busy, TCK is held low.
- R3: TMS and TDI change only in the system clock cycle where TCK falls, or in the cycle where a run begins (TCK is still low then). TDO is sampled at the rising TCK edge.
- R4: The first five TCK cycles of each run carry TMS=1, so every TAP reaches Test-Logic-Reset whatever state it started in.
- R5: The probe walks to Shift-IR with TMS values 0,1,1,0,0. It shifts MAX_DEV·MAX_IR ones on TDI and sets TMS=1 only on the last of them, then goes through Update-IR with TMS 1,0. Every device whose instruction length is at most MAX_IR ends up in BYPASS.
- R6: The probe enters Shift-DR with TMS 1,0,0 and shifts MAX_DEV zeros. It then drives a single TDI=1 followed by zeros. dev_count equals the number of rising edges that pass after the marker is taken in before TDO reads 1 (the chain length, 0 to MAX_DEV), and err is 0.
- R7: If TDO stays 0 for the marker's sample and the MAX_DEV samples after it, err is 1 and dev_count is 0.
- R8: If TDO is 1 at the sample of the last flush bit, the chain counts as stuck. err is 1, dev_count is 0, and no marker is sent.
- R9: Every run ends with TMS 1,1,0 after the measurement, which leaves all TAPs in Run-Test/Idle. Then done is high for exactly one system clock, in the same cycle that busy falls.
- R10: dev_count and err keep their values from the end of a run until the next accepted start.
- R11: A start pulse while busy is ignored. The run in progress keeps its TCK count and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a measurement when idle |
| busy | output | 1 | High while a measurement runs |
| done | output | 1 | One-cycle pulse at the end of a run |
| dev_count | output | $clog2(MAX_DEV+1) | Measured number of devices |
| err | output | 1 | No marker returned, or TDO stuck high |
| tck | output | 1 | Test clock to the chain |
| tms | output | 1 | Test mode select, shared by all TAPs |
| tdi | output | 1 | Serial data into the first device |
| tdo | input | 1 | Serial data from the last device |

## Verification
A wrong phase or bit index inside the sequencer shows up at once as a TMS or TDI value that differs from the fixed per-edge sequence. The bench records both lines at every rising TCK edge and compares them bit by bit, so a fault is localized to the exact TCK cycle. A TAP model with its own IR and BYPASS registers then turns a bad IR flood into a wrong count, because a device left in its ID instruction adds 32 cycles of delay. A miscounting measurement counter shows as a count that is off by one, or as an err flag with no cause, at the done pulse of the same run.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  // Order matters: the sequencer steps through these phases one after another.
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_RESET,    // TMS high x5
    PH_TO_IR,    // RTI, Select-DR, Select-IR, Capture-IR, Shift-IR
    PH_IR,       // ones flood, TMS high on last bit
    PH_IR_EXIT,  // Update-IR, Run-Test/Idle
    PH_TO_DR,    // Select-DR, Capture-DR, Shift-DR
    PH_FLUSH,    // zeros to clear bypass bits
    PH_MARK,     // single one, then zeros while counting
    PH_EXIT      // Exit1-DR, Update-DR, Run-Test/Idle
  } phase_e;

endpackage

// File: rtl/tcs_tck_gen.sv
module tcs_tck_gen #(
  parameter int TCK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tck,
  output logic rise_stb,
  output logic fall_stb
);

  localparam int CW = (TCK_DIV > 1) ? $clog2(TCK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TCK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          edge_w;

  assign edge_w   = en && (cnt_q == LAST);
  assign rise_stb = edge_w && !tck;
  assign fall_stb = edge_w && tck;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      tck   <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      tck   <= ~tck;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TCK_GATED: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tck); // R2

endmodule

// File: rtl/tcs_bitgen.sv
module tcs_bitgen
  import tcs_pkg::*;
#(
  parameter int MAX_DEV = 8,
  parameter int MAX_IR  = 6,
  parameter int IDXW    = 8
) (
  input  phase_e          phase,
  input  logic [IDXW-1:0] idx,
  output logic            tms_o,
  output logic            tdi_o,
  output logic            last_o
);

  localparam int              IR_BITS  = MAX_DEV * MAX_IR;
  localparam logic [IDXW-1:0] I0       = IDXW'(0);
  localparam logic [IDXW-1:0] I1       = IDXW'(1);
  localparam logic [IDXW-1:0] I2       = IDXW'(2);
  localparam logic [IDXW-1:0] I4       = IDXW'(4);
  localparam logic [IDXW-1:0] IR_LAST  = IDXW'(IR_BITS - 1);
  localparam logic [IDXW-1:0] FL_LAST  = IDXW'(MAX_DEV - 1);

  always_comb begin
    tms_o  = 1'b0;
    tdi_o  = 1'b0;
    last_o = 1'b0;
    unique case (phase)
      PH_RESET: begin
        tms_o  = 1'b1;
        last_o = (idx == I4);
      end
      PH_TO_IR: begin
        tms_o  = (idx == I1) || (idx == I2);
        last_o = (idx == I4);
      end
      PH_IR: begin
        tdi_o  = 1'b1;
        tms_o  = (idx == IR_LAST);
        last_o = (idx == IR_LAST);
      end
      PH_IR_EXIT: begin
        tms_o  = (idx == I0);
        last_o = (idx == I1);
      end
      PH_TO_DR: begin
        tms_o  = (idx == I0);
        last_o = (idx == I2);
      end
      PH_FLUSH: last_o = (idx == FL_LAST);
      PH_MARK:  tdi_o  = (idx == I0);
      PH_EXIT: begin
        tms_o  = (idx != I2);
        last_o = (idx == I2);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tcs_meas.sv
module tcs_meas #(
  parameter int MAX_DEV = 8,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          rise_stb,
  input  logic          in_mark,
  input  logic          flush_last,
  input  logic          tdo,
  output logic          res_valid,
  output logic [CW-1:0] count_q,
  output logic          err_q
);

  localparam logic [CW-1:0] CMAX = CW'(MAX_DEV);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q     <= '0;
      res_valid <= 1'b0;
      count_q   <= '0;
      err_q     <= 1'b0;
    end else if (rise_stb && !res_valid) begin
      if (flush_last && tdo) begin
        res_valid <= 1'b1;
        err_q     <= 1'b1;
        count_q   <= '0;
      end else if (in_mark) begin
        if (tdo) begin
          res_valid <= 1'b1;
          count_q   <= cnt_q;
        end else if (cnt_q == CMAX) begin
          res_valid <= 1'b1;
          err_q     <= 1'b1;
          count_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (count_q == '0)); // R7
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count_q <= CMAX); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !clr) |=> ($stable(count_q) && $stable(err_q))); // R10

endmodule

// File: rtl/tap_chain_sizer.sv
module tap_chain_sizer
  import tcs_pkg::*;
#(
  parameter int MAX_DEV = 8,
  parameter int MAX_IR  = 6,
  parameter int TCK_DIV = 2,
  localparam int CW     = $clog2(MAX_DEV + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] dev_count,
  output logic          err,
  output logic          tck,
  output logic          tms,
  output logic          tdi,
  input  logic          tdo
);

  localparam int IR_BITS = MAX_DEV * MAX_IR;
  localparam int IDXW    = $clog2(IR_BITS + MAX_DEV + 8);

  phase_e          phase_q, phase_n;
  logic [IDXW-1:0] idx_q, idx_n;
  logic            rise_stb, fall_stb;
  logic            cur_last, cur_tms_unused, cur_tdi_unused;
  logic            nxt_tms, nxt_tdi, nxt_last_unused;
  logic            res_valid;
  logic            accept;
  logic            finish;

  assign accept = start && !busy;
  assign finish = fall_stb && (phase_q == PH_EXIT) && cur_last;

  tcs_tck_gen #(.TCK_DIV(TCK_DIV)) u_tck (
    .clk      (clk),
    .rst      (rst),
    .en       (busy),
    .tck      (tck),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  // Decode of the bit being presented now (end-of-phase detection).
  tcs_bitgen #(.MAX_DEV(MAX_DEV), .MAX_IR(MAX_IR), .IDXW(IDXW)) u_cur (
    .phase  (phase_q),
    .idx    (idx_q),
    .tms_o  (cur_tms_unused),
    .tdi_o  (cur_tdi_unused),
    .last_o (cur_last)
  );

  // Decode of the bit that goes on the pins at the coming falling edge.
  tcs_bitgen #(.MAX_DEV(MAX_DEV), .MAX_IR(MAX_IR), .IDXW(IDXW)) u_nxt (
    .phase  (phase_n),
    .idx    (idx_n),
    .tms_o  (nxt_tms),
    .tdi_o  (nxt_tdi),
    .last_o (nxt_last_unused)
  );

  tcs_meas #(.MAX_DEV(MAX_DEV), .CW(CW)) u_meas (
    .clk        (clk),
    .rst        (rst),
    .clr        (accept),
    .rise_stb   (rise_stb),
    .in_mark    (phase_q == PH_MARK),
    .flush_last ((phase_q == PH_FLUSH) && cur_last),
    .tdo        (tdo),
    .res_valid  (res_valid),
    .count_q    (dev_count),
    .err_q      (err)
  );

  always_comb begin
    phase_n = phase_q;
    idx_n   = idx_q + 1'b1;
    unique case (phase_q)
      PH_IDLE: idx_n = '0;
      PH_MARK: begin
        idx_n = IDXW'(1);
        if (res_valid) begin
          phase_n = PH_EXIT;
          idx_n   = '0;
        end
      end
      PH_FLUSH: if (cur_last) begin
        phase_n = res_valid ? PH_EXIT : PH_MARK;
        idx_n   = '0;
      end
      PH_EXIT: if (cur_last) begin
        phase_n = PH_IDLE;
        idx_n   = '0;
      end
      default: if (cur_last) begin
        idx_n = '0;
        unique case (phase_q)
          PH_RESET:   phase_n = PH_TO_IR;
          PH_TO_IR:   phase_n = PH_IR;
          PH_IR:      phase_n = PH_IR_EXIT;
          PH_IR_EXIT: phase_n = PH_TO_DR;
          PH_TO_DR:   phase_n = PH_FLUSH;
          default:    phase_n = PH_IDLE;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      tms     <= 1'b0;
      tdi     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        phase_q <= PH_RESET;
        idx_q   <= '0;
        busy    <= 1'b1;
        tms     <= 1'b1;
        tdi     <= 1'b0;
      end else if (fall_stb) begin
        phase_q <= phase_n;
        idx_q   <= idx_n;
        tms     <= nxt_tms;
        tdi     <= nxt_tdi;
        if (finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_TCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tck); // R2
  AST_PIN_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    ((tms != $past(tms)) || (tdi != $past(tdi))) |-> (!tck && ($fell(tck) || $rose(busy)))); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !finish) |=> busy); // R11

endmodule

// File: tb/test_tap_chain_sizer.sv
`timescale 1ns/1ps
module test_tap_chain_sizer;

  localparam int MAXD  = 8;
  localparam int MAXIR = 6;
  localparam int DIV   = 2;
  localparam int IRB   = MAXD * MAXIR;
  localparam int CW    = $clog2(MAXD + 1);
  localparam real CLKP = 4.0;

  typedef enum int {TLR, RTI, SDR, CDR, SHDR, E1DR, PDR, E2DR, UDR,
                    SIR, CIR, SHIR, E1IR, PIR, E2IR, UIR} tap_e;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, err, tck, tms, tdi;
  logic [CW-1:0] dev_count;
  logic tdo;

  always #2 clk = ~clk;

  tap_chain_sizer #(.MAX_DEV(MAXD), .MAX_IR(MAXIR), .TCK_DIV(DIV)) i_tap_chain_sizer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .dev_count(dev_count), .err(err), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- chain model ----------------
  int   ndev = 0;
  int   fault = 0;
  int   ir_len [MAXD];
  logic [31:0]      drsh [MAXD];
  logic [MAXIR-1:0] irsh [MAXD];
  logic byp   [MAXD];
  logic tdo_q [MAXD];
  tap_e st = E2IR;
  bit   saw_tlr;
  int   nrise;
  logic rec_tms [512];
  logic rec_tdi [512];
  realtime last_rise;
  int   per_bad, pin_bad, done_bad;

  initial begin
    for (int d = 0; d < MAXD; d++) begin
      ir_len[d] = 2; drsh[d] = '0; irsh[d] = '0; byp[d] = 1'b0; tdo_q[d] = 1'b0;
    end
  end

  function automatic tap_e tap_next(tap_e s, logic m);
    case (s)
      TLR:  return m ? TLR  : RTI;
      RTI:  return m ? SDR  : RTI;
      SDR:  return m ? SIR  : CDR;
      CDR:  return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR  : PDR;
      PDR:  return m ? E2DR : PDR;
      E2DR: return m ? UDR  : SHDR;
      UDR:  return m ? SDR  : RTI;
      SIR:  return m ? TLR  : CIR;
      CIR:  return m ? E1IR : SHIR;
      SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR  : PIR;
      PIR:  return m ? E2IR : PIR;
      E2IR: return m ? UIR  : SHIR;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    if (nrise < 512) begin
      rec_tms[nrise] = tms;
      rec_tdi[nrise] = tdi;
    end
    if (nrise > 0 && ($realtime - last_rise) != 2.0 * DIV * CLKP) per_bad++;
    last_rise = $realtime;
    nrise++;
    for (int d = 0; d < MAXD; d++) begin
      logic din;
      logic [MAXIR-1:0] t;
      logic [MAXIR-1:0] mask;
      din  = (d == 0) ? tdi : tdo_q[(d > 0) ? d - 1 : 0];
      mask = MAXIR'((1 << ir_len[d]) - 1);
      case (st)
        TLR:  byp[d] <= 1'b0;
        CIR:  irsh[d] <= MAXIR'(1);
        SHIR: begin
          t = irsh[d] >> 1;
          t[ir_len[d] - 1] = din;
          irsh[d] <= t;
        end
        UIR:  byp[d] <= ((irsh[d] | ~mask) == '1);
        CDR:  drsh[d] <= byp[d] ? 32'h0 : (32'h1000_0001 | (32'(d) << 12));
        SHDR: drsh[d] <= byp[d] ? {31'h0, din} : {din, drsh[d][31:1]};
        default: ;
      endcase
    end
    if (st == TLR) saw_tlr = 1'b1;
    st <= tap_next(st, tms);
  end

  always @(negedge tck) begin
    for (int d = 0; d < MAXD; d++) begin
      if (st == SHIR)      tdo_q[d] <= irsh[d][0];
      else if (st == SHDR) tdo_q[d] <= drsh[d][0];
    end
  end

  always_comb begin
    if (fault == 1)      tdo = 1'b0;
    else if (fault == 2) tdo = 1'b1;
    else if (ndev == 0)  tdo = tdi;
    else                 tdo = tdo_q[ndev - 1];
  end

  // ---------------- pin monitors (R3, R9) ----------------
  logic ptms = 0, ptdi = 0, ptck = 0, pbusy = 0, pdone = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (((tms != ptms) || (tdi != ptdi)) && !(!tck && (ptck || !pbusy))) pin_bad++;
      if (done && pdone) done_bad++;
    end
    ptms = tms; ptdi = tdi; ptck = tck; pbusy = busy; pdone = done;
  end

  // ---------------- expected sequences ----------------
  function automatic logic exp_tms(int i, int m);
    if (i < 5) return 1'b1;
    i -= 5;    if (i < 5) return (i == 1 || i == 2);
    i -= 5;    if (i < IRB) return (i == IRB - 1);
    i -= IRB;  if (i < 2) return (i == 0);
    i -= 2;    if (i < 3) return (i == 0);
    i -= 3;    if (i < MAXD) return 1'b0;
    i -= MAXD; if (i < m) return 1'b0;
    i -= m;    return (i != 2);
  endfunction

  function automatic logic exp_tdi(int i, int m);
    if (i < 10) return 1'b0;
    i -= 10;        if (i < IRB) return 1'b1;
    i -= IRB + 5 + MAXD;
    return (i == 0 && m > 0);
  endfunction

  task automatic do_run(input int n, input int f, input bit extra);
    int cyc, m, expc, tbad, dbad, total, nbyp;
    bit experr;
    ndev = n; fault = f;
    for (int d = 0; d < MAXD; d++) ir_len[d] = $urandom_range(2, MAXIR);
    nrise = 0; per_bad = 0; pin_bad = 0; done_bad = 0; saw_tlr = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start = (extra && (cyc == 40 || cyc == 41));
    end
    start = 1'b0;
    m      = (f == 0) ? n + 1 : (f == 1) ? MAXD + 1 : 0;
    expc   = (f == 0) ? n : 0;
    experr = (f != 0);
    total  = 18 + IRB + MAXD + m;
    chk(done === 1'b1 && busy === 1'b0, "R9 done with busy low", int'(busy), 0);
    chk(dev_count == CW'(expc), (f == 0) ? "R6 device count" : "R7/R8 count zero on error", int'(dev_count), expc);
    chk(err == experr, (f == 1) ? "R7 timeout flag" : (f == 2) ? "R8 stuck-high flag" : "R6 no error", int'(err), int'(experr));
    chk(nrise == total, extra ? "R11 run length with extra start" : "R9 run length", nrise, total);
    tbad = 0; dbad = 0;
    for (int i = 0; i < total && i < 512; i++) begin
      if (rec_tms[i] !== exp_tms(i, m)) tbad++;
      if (rec_tdi[i] !== exp_tdi(i, m)) dbad++;
    end
    chk(saw_tlr && rec_tms[0] && rec_tms[1] && rec_tms[2] && rec_tms[3] && rec_tms[4], "R4 reset prefix", int'(saw_tlr), 1);
    chk(tbad == 0, "R5 TMS sequence", tbad, 0);
    chk(dbad == 0, "R5 TDI sequence", dbad, 0);
    nbyp = 0;
    for (int d = 0; d < n; d++) if (byp[d]) nbyp++;
    chk(nbyp == n, "R5 all devices in bypass", nbyp, n);
    chk(st == RTI, "R9 chain in Run-Test/Idle", int'(st), int'(RTI));
    chk(per_bad == 0, "R2 TCK period", per_bad, 0);
    chk(pin_bad == 0, "R3 pins change on falling TCK", pin_bad, 0);
    repeat (2) @(negedge clk);
    chk(done_bad == 0 && !done, "R9 done single cycle", done_bad, 0);
    repeat (15) @(negedge clk);
    chk(dev_count == CW'(expc) && err == experr, "R10 result held", int'(dev_count), expc);
    chk(!tck && !busy, "R2 TCK low when idle", int'(tck), 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLKP * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !tck && !tms && !tdi && dev_count == 0, "R1 reset state",
        int'({busy, done, err, tck, tms, tdi}), 0);
    do_run(0, 0, 0);       // empty chain
    do_run(MAXD, 0, 0);    // full chain
    do_run(3, 0, 1);       // start while busy (R11)
    do_run(4, 1, 0);       // stuck low -> timeout
    do_run(2, 2, 0);       // stuck high
    for (int k = 0; k < 10; k++) do_run($urandom_range(0, MAXD), 0, ($urandom_range(0, 3) == 0));
    summary();
  end

endmodule